// File: doc/BRIEF.md
# S/T Interface Frame Transmitter

This block builds the 48-bit frame that a terminal sends towards the network on a basic-rate ISDN S/T interface. Each frame carries four B octets (two for B1, two for B2) and four D bits. The frames go out at one bit per bit-rate tick, which gives 48 ticks per 250 µs frame and a 192 kbit/s line rate. Each bit is emitted as a pseudo-ternary symbol code. A binary one is sent as no pulse. A binary zero is sent as a full-width pulse whose polarity alternates. The analog line driver converts the two-bit code into line levels.

A bit-rate timing source supplies a one-cycle `bit_en_i` pulse per bit period. It also supplies a strobe on `frm_sync_i` that marks the received frame boundary. The transmit framing bit follows that boundary by a parameterised number of bit periods, two by default. The payload on the data inputs is captured at the strobe and goes out in the next frame that starts. Once started, frames repeat back to back without further strobes. A strobe at a new phase realigns the frame timing. The auxiliary framing bit in the frame is held at a fixed value.

Top module: `st_frame_tx`

## Requirements
- R1: After reset `sym_o` is 2'b00 and `frame_o` is 0. Both stay there until the first frame begins, including for any number of bit ticks before the first strobe.
- R2: Symbol codes are 2'b01 for a positive pulse, 2'b10 for a negative pulse and 2'b00 for no pulse. A binary 1 is always 2'b00. The code 2'b11 never appears.
- R3: The framing bit is emitted OFFSET (default 2) bit ticks after the tick that carries a strobe. It is a positive pulse (2'b01). `frame_o` is 1 for exactly that bit period.
- R4: The bit after the framing bit is a balancing bit, sent as a negative pulse (2'b10).
- R5: Frame positions (0 = framing bit) are as follows:
  - B1 first octet (`b1_i[7:0]`) at 2..9.
  - D bit `d_i[0]` at 11.
  - Auxiliary framing bit, fixed at binary 0, at 13.
  - B2 first octet (`b2_i[7:0]`) at 15..22.
  - `d_i[1]` at 24.
  - B1 second octet (`b1_i[15:8]`) at 26..33.
  - `d_i[2]` at 35.
  - B2 second octet (`b2_i[15:8]`) at 37..44.
  - `d_i[3]` at 46.
  - Octets are sent most significant bit first.
- R6: The first zero after the framing/balancing pair is a positive pulse. Every later zero in the frame, balancing bits included, takes the polarity opposite to the previous pulse.
- R7: Positions 10, 12, 14, 23, 25, 34, 36, 45 and 47 are balancing bits. Each one is binary 0 when the field since the previous balancing bit held an odd number of zeros, and binary 1 otherwise.
- R8: Data inputs are captured only on a strobe tick. Changes without a strobe, or between a strobe and the next framing bit, do not alter any frame that has already started.
- R9: Every complete frame holds as many positive as negative pulses.
- R10: Without further strobes, framing bits recur every 48 ticks. A strobe in mid-frame restarts the frame OFFSET ticks later.
- R11: `sym_o` and `frame_o` change only on clock edges where `bit_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en_i | input | 1 | One-cycle tick per line bit period |
| frm_sync_i | input | 1 | Received frame boundary strobe, valid with `bit_en_i` |
| b1_i | input | 16 | Two B1 octets, first octet in bits 7:0 |
| b2_i | input | 16 | Two B2 octets, first octet in bits 7:0 |
| d_i | input | 4 | Four D bits, bit 0 sent first |
| sym_o | output | 2 | Pseudo-ternary symbol code for the current bit period |
| frame_o | output | 1 | High during the framing bit period |

## Verification
A wrong parity flag shows up at the next balancing bit, at most nine bit periods away. Every pulse after it then has the wrong polarity until the balancing bit after the framing bit reloads the polarity reference. So a polarity or parity fault persists to the end of the frame but never crosses into the next one. A wrong position count shifts the framing marker and every field at once, and this is visible on the very next tick. A wrong payload latch point shows only in the frame that follows the input change. The bench therefore changes inputs at several points around the strobe and checks each full frame.

// File: rtl/st_tx_pkg.sv
`timescale 1ns/1ps
package st_tx_pkg;

    localparam int OCT_W     = 8;
    localparam int NUM_D     = 4;

    // field start positions; each B/D/aux field is followed by one balancing slot
    localparam int P_B1A     = 2;
    localparam int P_D1      = P_B1A + OCT_W + 1;
    localparam int P_FA      = P_D1 + 2;
    localparam int P_B2A     = P_FA + 2;
    localparam int P_D2      = P_B2A + OCT_W + 1;
    localparam int P_B1B     = P_D2 + 2;
    localparam int P_D3      = P_B1B + OCT_W + 1;
    localparam int P_B2B     = P_D3 + 2;
    localparam int P_D4      = P_B2B + OCT_W + 1;
    localparam int FRAME_LEN = P_D4 + 2;
    localparam int POS_W     = $clog2(FRAME_LEN);

    typedef enum logic [1:0] {
        SYM_NONE = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b10
    } sym_t;

    typedef enum logic [1:0] {
        K_FRM,
        K_FBAL,
        K_DATA,
        K_BAL
    } kind_t;

    typedef struct packed {
        logic [1:0][OCT_W-1:0] b1;
        logic [1:0][OCT_W-1:0] b2;
        logic [NUM_D-1:0]      d;
    } payload_t;

    function automatic logic is_bal_slot(input int p);
        return (p == P_D1 - 1) || (p == P_D1 + 1) || (p == P_FA + 1) ||
               (p == P_D2 - 1) || (p == P_D2 + 1) ||
               (p == P_D3 - 1) || (p == P_D3 + 1) ||
               (p == P_D4 - 1) || (p == P_D4 + 1);
    endfunction

    function automatic kind_t slot_kind(input logic [POS_W-1:0] pos);
        int p;
        p = int'(pos);
        if (p == 0)
            return K_FRM;
        else if (p == 1)
            return K_FBAL;
        else if (is_bal_slot(p))
            return K_BAL;
        else
            return K_DATA;
    endfunction

    function automatic logic [FRAME_LEN-1:0] pack_frame(input payload_t pl, input logic fa);
        logic [FRAME_LEN-1:0] v;
        v = '1;
        for (int i = 0; i < OCT_W; i++) begin
            v[P_B1A + i] = pl.b1[0][OCT_W-1-i];
            v[P_B2A + i] = pl.b2[0][OCT_W-1-i];
            v[P_B1B + i] = pl.b1[1][OCT_W-1-i];
            v[P_B2B + i] = pl.b2[1][OCT_W-1-i];
        end
        v[P_D1] = pl.d[0];
        v[P_D2] = pl.d[1];
        v[P_D3] = pl.d[2];
        v[P_D4] = pl.d[3];
        v[P_FA] = fa;
        return v;
    endfunction

    function automatic sym_t flip_pol(input sym_t s);
        return (s == SYM_POS) ? SYM_NEG : SYM_POS;
    endfunction

endpackage

// File: rtl/st_tx_seq.sv
`timescale 1ns/1ps
module st_tx_seq
    import st_tx_pkg::*;
#(
    parameter int OFFSET = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             sync_i,
    output logic             emit_o,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] LOAD_POS = POS_W'((FRAME_LEN + 1 - OFFSET) % FRAME_LEN);

    logic [POS_W-1:0] pos_q;
    logic             arm_q;
    logic             run_q;
    logic             live;

    assign live   = arm_q && (run_q || (pos_q == '0));
    assign emit_o = tick_i && live;
    assign pos_o  = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            arm_q <= 1'b0;
            run_q <= 1'b0;
        end else if (tick_i) begin
            if (live)
                run_q <= 1'b1;
            if (sync_i) begin
                pos_q <= LOAD_POS;
                arm_q <= 1'b1;
            end else if (pos_q == LAST_POS) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    p_pos_range_r10: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

    p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !sync_i && pos_q == LAST_POS) |=> (pos_q == '0));

endmodule

// File: rtl/st_tx_fmt.sv
`timescale 1ns/1ps
module st_tx_fmt
    import st_tx_pkg::*;
#(
    parameter logic FA_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic             load_i,
    input  payload_t         pay_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             bit_o,
    output kind_t            kind_o
);
    payload_t             stage_q;
    payload_t             act_q;
    logic [FRAME_LEN-1:0] line_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            act_q   <= '0;
        end else begin
            if (capture_i)
                stage_q <= pay_i;
            if (load_i)
                act_q <= stage_q;
        end
    end

    always_comb begin
        line_w = pack_frame(act_q, FA_VAL);
        bit_o  = line_w[pos_i];
        kind_o = slot_kind(pos_i);
    end

    p_act_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !$past(rst)) |=> (act_q == $past(act_q)));

endmodule

// File: rtl/st_tx_coder.sv
`timescale 1ns/1ps
module st_tx_coder
    import st_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       emit_i,
    input  kind_t      kind_i,
    input  logic       bit_i,
    output logic [1:0] sym_o,
    output logic       frame_o
);
    sym_t sym_q;
    sym_t pol_q;
    logic odd_q;
    logic frm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= SYM_NONE;
            pol_q <= SYM_POS;
            odd_q <= 1'b0;
            frm_q <= 1'b0;
        end else if (tick_i) begin
            sym_q <= SYM_NONE;
            frm_q <= 1'b0;
            if (emit_i) begin
                case (kind_i)
                    K_FRM: begin
                        sym_q <= SYM_POS;
                        frm_q <= 1'b1;
                        odd_q <= 1'b0;
                    end
                    K_FBAL: begin
                        sym_q <= SYM_NEG;
                        pol_q <= SYM_POS;
                        odd_q <= 1'b0;
                    end
                    K_DATA: begin
                        if (!bit_i) begin
                            sym_q <= pol_q;
                            pol_q <= flip_pol(pol_q);
                            odd_q <= ~odd_q;
                        end
                    end
                    default: begin
                        if (odd_q) begin
                            sym_q <= pol_q;
                            pol_q <= flip_pol(pol_q);
                        end
                        odd_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sym_o   = sym_q;
    assign frame_o = frm_q;

    // observation state for the polarity checks
    logic new_q, fb_q, lastfb_q, seen_q;
    sym_t lastp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            new_q    <= 1'b0;
            fb_q     <= 1'b0;
            lastfb_q <= 1'b0;
            seen_q   <= 1'b0;
            lastp_q  <= SYM_NONE;
        end else begin
            new_q <= tick_i;
            if (tick_i) begin
                fb_q <= emit_i && (kind_i == K_FBAL);
                if (sym_q != SYM_NONE) begin
                    lastp_q  <= sym_q;
                    lastfb_q <= fb_q;
                    seen_q   <= 1'b1;
                end
            end
        end
    end

    p_frame_pos_r3: assert property (@(posedge clk) disable iff (rst)
        frm_q |-> (sym_q == SYM_POS));

    p_alternate_r6: assert property (@(posedge clk) disable iff (rst)
        (new_q && seen_q && sym_q != SYM_NONE && !frm_q && !fb_q && !lastfb_q)
        |-> (sym_q != lastp_q));

    p_first_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (new_q && sym_q != SYM_NONE && lastfb_q && !frm_q) |-> (sym_q == SYM_POS));

    p_code_r2: assert property (@(posedge clk) disable iff (rst)
        sym_o != 2'b11);

endmodule

// File: rtl/st_frame_tx.sv
`timescale 1ns/1ps
module st_frame_tx
    import st_tx_pkg::*;
#(
    parameter int   OFFSET = 2,
    parameter logic FA_VAL = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bit_en_i,
    input  logic                      frm_sync_i,
    input  logic [2*OCT_W-1:0]        b1_i,
    input  logic [2*OCT_W-1:0]        b2_i,
    input  logic [NUM_D-1:0]          d_i,
    output logic [1:0]                sym_o,
    output logic                      frame_o
);
    logic             emit;
    logic [POS_W-1:0] pos;
    logic             bit_w;
    kind_t            kind_w;
    payload_t         pay;
    logic             capture;
    logic             load;

    always_comb begin
        pay.b1[0] = b1_i[OCT_W-1:0];
        pay.b1[1] = b1_i[2*OCT_W-1:OCT_W];
        pay.b2[0] = b2_i[OCT_W-1:0];
        pay.b2[1] = b2_i[2*OCT_W-1:OCT_W];
        pay.d     = d_i;
    end

    assign capture = bit_en_i && frm_sync_i;
    assign load    = emit && (pos == '0);

    st_tx_seq #(.OFFSET(OFFSET)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick_i (bit_en_i),
        .sync_i (frm_sync_i),
        .emit_o (emit),
        .pos_o  (pos)
    );

    st_tx_fmt #(.FA_VAL(FA_VAL)) u_fmt (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .load_i    (load),
        .pay_i     (pay),
        .pos_i     (pos),
        .bit_o     (bit_w),
        .kind_o    (kind_w)
    );

    st_tx_coder u_coder (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (bit_en_i),
        .emit_i  (emit),
        .kind_i  (kind_w),
        .bit_i   (bit_w),
        .sym_o   (sym_o),
        .frame_o (frame_o)
    );

    logic started_q;
    always_ff @(posedge clk) begin
        if (rst)
            started_q <= 1'b0;
        else if (frame_o)
            started_q <= 1'b1;
    end

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!started_q && !frame_o) |-> (sym_o == 2'b00));

    p_fbal_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_en_i && frame_o) |=> (sym_o == 2'b10));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_en_i) |-> ($stable(sym_o) && $stable(frame_o)));

endmodule

// File: tb/sim_st_frame_tx.sv
`timescale 1ns/1ps
module sim_st_frame_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        frm_sync = 1'b0;
    logic [15:0] b1 = '0;
    logic [15:0] b2 = '0;
    logic [3:0]  d = '0;
    logic [1:0]  sym;
    logic        frame;

    st_frame_tx u0 (
        .clk        (clk),
        .rst        (rst),
        .bit_en_i   (bit_en),
        .frm_sync_i (frm_sync),
        .b1_i       (b1),
        .b2_i       (b2),
        .d_i        (d),
        .sym_o      (sym),
        .frame_o    (frame)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [15:0] b1;
        logic [15:0] b2;
        logic [3:0]  d;
    } pay_t;

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    pay_t       stg;
    pay_t       act;
    logic [1:0] exp_s [48];

    task automatic chk(input string rq, input string tag, input string what,
                       input int got, input int want);
        n_chk++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", rq, tag, what, got, want);
        end
    endtask

    function automatic pay_t mk(input int k);
        pay_t p;
        if (k == 0) begin
            p.b1 = 16'h0000; p.b2 = 16'h0000;
        end else if (k == 15) begin
            p.b1 = 16'hFFFF; p.b2 = 16'hFFFF;
        end else begin
            p.b1 = {8'(k * 37 + 3), 8'(k * 91)};
            p.b2 = {8'(~(k * 53)), 8'(k * 17 + 200)};
        end
        p.d = 4'(k);
        return p;
    endfunction

    function automatic bit bal_pos(input int p);
        return p == 10 || p == 12 || p == 14 || p == 23 || p == 25 ||
               p == 34 || p == 36 || p == 45 || p == 47;
    endfunction

    task automatic drive(input pay_t p);
        b1 = p.b1; b2 = p.b2; d = p.d;
    endtask

    // expected symbols, walked field by field from the requirements
    task automatic fill(input pay_t p);
        int val [9];
        int wid [9];
        int k;
        int cnt;
        logic [1:0] pol;
        val = '{int'(p.b1[7:0]), int'(p.d[0]), 0, int'(p.b2[7:0]), int'(p.d[1]),
                int'(p.b1[15:8]), int'(p.d[2]), int'(p.b2[15:8]), int'(p.d[3])};
        wid = '{8, 1, 1, 8, 1, 8, 1, 8, 1};
        exp_s[0] = 2'b01;
        exp_s[1] = 2'b10;
        pol = 2'b01;
        k = 2;
        for (int f = 0; f < 9; f++) begin
            cnt = 0;
            for (int i = wid[f] - 1; i >= 0; i--) begin
                if (((val[f] >> i) & 1) == 0) begin
                    exp_s[k] = pol;
                    pol = (pol == 2'b01) ? 2'b10 : 2'b01;
                    cnt++;
                end else begin
                    exp_s[k] = 2'b00;
                end
                k++;
            end
            if (cnt % 2 == 1) begin
                exp_s[k] = pol;
                pol = (pol == 2'b01) ? 2'b10 : 2'b01;
            end else begin
                exp_s[k] = 2'b00;
            end
            k++;
        end
    endtask

    task automatic tick(input bit s, output logic [1:0] s1, output logic f1);
        @(negedge clk);
        bit_en = 1'b1;
        frm_sync = s;
        @(negedge clk);
        bit_en = 1'b0;
        frm_sync = 1'b0;
        s1 = sym;
        f1 = frame;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "hold", "sym", int'(sym), int'(s1));
        chk("R11", "hold", "marker", int'(frame), int'(f1));
    endtask

    task automatic run_frame(input string tag, input int sync_pos, input int chg_pos,
                             input pay_t chg, input int stop_pos);
        logic [1:0] s1;
        logic       f1;
        int         np;
        int         nn;
        string      rq;
        act = stg;
        fill(act);
        np = 0;
        nn = 0;
        for (int p = 0; p < 48; p++) begin
            if (p == chg_pos)
                drive(chg);
            if (p == sync_pos) begin
                stg.b1 = b1; stg.b2 = b2; stg.d = d;
            end
            tick(p == sync_pos, s1, f1);
            rq = (p == 0) ? "R3" : (p == 1) ? "R4" : bal_pos(p) ? "R7 R6" : "R5 R6";
            chk(rq, tag, $sformatf("symbol at %0d", p), int'(s1), int'(exp_s[p]));
            chk("R3", tag, $sformatf("marker at %0d", p), int'(f1), (p == 0) ? 1 : 0);
            chk("R2", tag, "code legal", (s1 != 2'b11) ? 1 : 0, 1);
            if (s1 == 2'b01) np++;
            if (s1 == 2'b10) nn++;
            if (p == stop_pos)
                return;
        end
        chk("R9", tag, "positive vs negative pulses", np, nn);
    endtask

    initial begin
        logic [1:0] s1;
        logic       f1;
        pay_t       pa, pb, pc;
        pa.b1 = 16'hA53C; pa.b2 = 16'h0F81; pa.d = 4'b0110;
        pb.b1 = 16'h1200; pb.b2 = 16'hFE7D; pb.d = 4'b1001;
        pc.b1 = 16'h5555; pc.b2 = 16'hAAAA; pc.d = 4'b0000;

        drive(pa);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset", "sym", int'(sym), 0);
        chk("R1", "reset", "marker", int'(frame), 0);
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, s1, f1);
            chk("R1", "no strobe", "sym", int'(s1), 0);
        end

        stg = pa;
        tick(1'b1, s1, f1);
        chk("R1", "strobe tick", "sym", int'(s1), 0);
        tick(1'b0, s1, f1);
        chk("R3", "offset tick", "sym", int'(s1), 0);
        chk("R3", "offset tick", "marker", int'(f1), 0);

        // R8: inputs change mid-frame without a strobe
        run_frame("R8 first frame", -1, 20, pb, -1);
        // R10: free-running repeat of the same payload, strobe captures pb
        run_frame("R10 free run", 46, 47, pc, -1);
        // R8: change after strobe does not reach this frame
        run_frame("R8 after strobe", 46, 10, mk(0), -1);
        for (int k = 1; k < 16; k++)
            run_frame("R5 sweep", 46, 10, mk(k), -1);

        // R10: strobe in mid-frame realigns
        run_frame("R10 realign", 20, 5, mk(7), 20);
        tick(1'b0, s1, f1);
        chk("R10", "realign gap", "marker", int'(f1), 0);
        run_frame("R10 realigned", -1, -1, mk(7), -1);
        run_frame("R10 repeat", -1, -1, mk(7), -1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule